// File: doc/BRIEF.md
# General-Purpose Register Bank with Same-Cycle Write Bypass

This block holds the architectural integer registers of a pipelined processor core. The decode stage presents two source register numbers and gets both operand values back in the same cycle, with no clock edge between address and data. The writeback stage presents one destination register number, a data word and an enable. The word is stored at the clock edge that ends the writeback cycle.

A decode read and a writeback write can name the same register in the same cycle. In that case the bank returns the word being written, not the old stored contents. The forwarding from writeback to decode therefore happens inside the bank, and the pipeline needs no separate path for that distance. Register 0 is a constant zero. Writes to it are discarded, and it never takes part in the bypass. A synchronous reset clears every entry.

Top module: `gpr_bank`

## Requirements
- R1: After a synchronous reset (`rst` high for at least one rising edge), every register reads as 0 on both read ports until it is written.
- R2: The two read ports are independent. `rs_a_data` depends only on `rs_a_addr`, `rs_b_data` depends only on `rs_b_addr`, and both are valid in the same cycle as their addresses, for any pair of addresses, including two equal addresses.
- R3: When `wr_en` is 1 and `wr_addr` is not 0, `wr_data` is stored at the rising edge that ends that cycle. A later read of that register returns it, until the next write to that register.
- R4: When `wr_en` is 1, `wr_addr` is not 0 and `wr_addr` equals a port's read address, that port returns `wr_data` in the same cycle rather than the stored value.
- R5: A read with address 0 returns 0 on either port in every cycle.
- R6: A write with `wr_addr` equal to 0 stores nothing, and it is not bypassed: a port reading address 0 still returns 0.
- R7: When `wr_en` is 0, no register changes and no bypass is applied. A read of the address on `wr_addr` returns the stored value.
- R8: A write to one register leaves the contents of every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| wr_en | input | 1 | Write enable from writeback |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Data word to store |
| rs_a_addr | input | 5 | First source register number |
| rs_a_data | output | 32 | First operand value, same cycle |
| rs_b_addr | input | 5 | Second source register number |
| rs_b_data | output | 32 | Second operand value, same cycle |

## Verification
A wrong stored entry appears on a read port as soon as that register is addressed, and a faulty bypass appears in the very cycle of the colliding write. The bench therefore reads through the bypass in every write cycle and re-reads the stored word in later cycles. A write that lands in the wrong entry, or a broken reset clear, surfaces one cycle later. The bench finds both with a full sweep of all 1024 read-address pairs after each fill pattern. Both ports see the same inputs, so a fault confined to one port shows up as a mismatch between the ports.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef struct packed {
    logic        en;
    logic [4:0]  addr;
    logic [31:0] data;
  } gpr_wr_t;

  function automatic logic addr_is_zero(input logic [4:0] a);
    return a == '0;
  endfunction
endpackage

// File: rtl/gpr_wr_qual.sv
module gpr_wr_qual #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              en_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              en_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out
);
  // register 0 is a constant: a write to it is neither stored nor bypassed
  assign en_out   = en_in && (addr_in != '0);
  assign addr_out = addr_in;
  assign data_out = data_in;
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DEPTH-1:0][DATA_W-1:0]  words
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign words = mem_q;
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] words,
  input  logic [ADDR_W-1:0]            raddr,
  input  logic                         byp_en,
  input  logic [ADDR_W-1:0]            byp_addr,
  input  logic [DATA_W-1:0]            byp_data,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    if (raddr == '0) begin
      rdata = '0;
    end else if (byp_en && (byp_addr == raddr)) begin
      rdata = byp_data;
    end else begin
      rdata = words[raddr];
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rs_a_addr,
  output logic [DATA_W-1:0] rs_a_data,
  input  logic [ADDR_W-1:0] rs_b_addr,
  output logic [DATA_W-1:0] rs_b_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NPORTS = 2;

  logic                         q_en;
  logic [ADDR_W-1:0]            q_addr;
  logic [DATA_W-1:0]            q_data;
  logic [DEPTH-1:0][DATA_W-1:0] words;
  logic [NPORTS-1:0][ADDR_W-1:0] port_addr;
  logic [NPORTS-1:0][DATA_W-1:0] port_data;

  gpr_wr_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wq_i (
    .en_in(wr_en), .addr_in(wr_addr), .data_in(wr_data),
    .en_out(q_en), .addr_out(q_addr), .data_out(q_data)
  );

  gpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) st_i (
    .clk(clk), .rst(rst), .we(q_en), .waddr(q_addr), .wdata(q_data),
    .words(words)
  );

  assign port_addr[0] = rs_a_addr;
  assign port_addr[1] = rs_b_addr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    gpr_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rp_i (
      .words(words), .raddr(port_addr[p]),
      .byp_en(q_en), .byp_addr(q_addr), .byp_data(q_data),
      .rdata(port_data[p])
    );
  end

  assign rs_a_data = port_data[0];
  assign rs_b_data = port_data[1];
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rs_a_addr,
  input logic [DATA_W-1:0] rs_a_data,
  input logic [ADDR_W-1:0] rs_b_addr,
  input logic [DATA_W-1:0] rs_b_data
);
  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rs_a_addr == '0) |-> (rs_a_data == '0)); // R5
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rs_b_addr == '0) |-> (rs_b_data == '0)); // R5
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && wr_addr == rs_a_addr) |-> (rs_a_data == wr_data)); // R4
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && wr_addr == rs_b_addr) |-> (rs_b_data == wr_data)); // R4
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rs_a_addr == rs_b_addr) |-> (rs_a_data == rs_b_data)); // R2
  AST_COMMIT_A: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      ((rs_a_addr != $past(wr_addr)) || (wr_en && wr_addr == rs_a_addr)
       || (rs_a_data == $past(wr_data)))); // R3
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=>
      (!($stable(rs_a_addr) && !(wr_en && wr_addr == rs_a_addr)) || $stable(rs_a_data))); // R7
endmodule

bind gpr_bank gpr_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rs_a_addr(rs_a_addr), .rs_a_data(rs_a_data),
  .rs_b_addr(rs_b_addr), .rs_b_data(rs_b_data)
);

// File: tb/gpr_bank_tb_top.sv
`timescale 1ns/1ps
module gpr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rs_a_addr = '0;
  logic [4:0]  rs_b_addr = '0;
  logic [31:0] rs_a_data;
  logic [31:0] rs_b_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpr_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rs_a_addr(rs_a_addr), .rs_a_data(rs_a_data),
    .rs_b_addr(rs_b_addr), .rs_b_data(rs_b_data)
  );

  function automatic logic [31:0] pat(input int sel, input int r);
    if (sel == 0) return 32'h0101_0101 * r + 32'h5A00_0000;
    return ~(32'h0003_0007 * r) ^ 32'h00C0_FFEE;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [4:0] ra);
    if (ra == 0) return 32'd0;
    if (wr_en && wr_addr == ra) return wr_data;
    return model[ra];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, commit into the model at the next posedge
  task automatic cycle(input logic en, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb, input string req);
    @(negedge clk);
    wr_en = en; wr_addr = wa; wr_data = wd; rs_a_addr = ra; rs_b_addr = rb;
    #1;
    chk(req, rs_a_data, expect_rd(ra));
    chk(req, rs_b_data, expect_rd(rb));
    @(posedge clk);
    if (en && wa != 0) model[wa] = wd;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        cycle(1'b0, 5'd0, 32'd0, a[4:0], b[4:0], req);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: cleared after reset, both ports, equal and distinct addresses (R2)
    sweep("R1/R2 reset clear sweep");
    // R3/R4: fill, bypass on port A, port B reads the previously committed entry
    for (int r = 1; r < 32; r++)
      cycle(1'b1, r[4:0], pat(0, r), r[4:0], 5'(r - 1), "R3/R4 fill with bypass");
    // R6: write to register 0 is neither bypassed nor stored; R5 zero read
    cycle(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R6 zero write no bypass");
    cycle(1'b0, 5'd0, 32'd0, 5'd0, 5'd1, "R5/R6 zero after write");
    sweep("R2/R3 full sweep pattern 0");
    // R7: disabled write to a matched address: stored value shown, nothing changes
    for (int r = 1; r < 32; r++) begin
      cycle(1'b0, r[4:0], 32'hFFFF_0000 ^ r, r[4:0], r[4:0], "R7 no bypass when disabled");
      cycle(1'b0, 5'd0, 32'd0, r[4:0], 5'd0, "R7 no store when disabled");
      chk("R7 stored value kept", rs_a_data, pat(0, r));
    end
    // R8: rewrite odd registers only, even ones must keep pattern 0
    for (int r = 1; r < 32; r += 2)
      cycle(1'b1, r[4:0], pat(1, r), 5'(r + 1), r[4:0], "R8/R4 partial rewrite");
    for (int r = 2; r < 32; r += 2) begin
      cycle(1'b0, 5'd0, 32'd0, r[4:0], 5'(r - 1), "R8 neighbours intact");
      chk("R8 even register unchanged", rs_a_data, pat(0, r));
    end
    // back-to-back writes to one register, bypass on both ports (R4)
    cycle(1'b1, 5'd7, 32'h1111_1111, 5'd7, 5'd7, "R4 back-to-back 1");
    cycle(1'b1, 5'd7, 32'h2222_2222, 5'd7, 5'd7, "R4 back-to-back 2");
    cycle(1'b0, 5'd0, 32'd0, 5'd7, 5'd6, "R3 last write wins");
    chk("R3 last write wins literal", rs_a_data, 32'h2222_2222);
    sweep("R2/R8 full sweep mixed");
    // reset again clears everything (R1)
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    @(negedge clk) rst = 1'b0;
    sweep("R1 second reset clear");
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule